// File: doc/BRIEF.md
# Video Display Controller CPU Port

This block is the host-facing side of a tile-based video display processor. A CPU reaches it through one 8-bit data bus, a select line that chooses between a data port and a control port, and a write strobe. The block holds the processor's eight 8-bit configuration registers and a 14-bit video memory write pointer. It turns CPU writes into register updates, pointer loads and video memory writes.

A control action always takes two writes to the control port. The first byte is only held. The second byte says what the pair means. Its top bits select either a register load, which places the held byte into one of the eight registers, or a pointer load, which uses the held byte as the low half of the address. Once the pointer is set, each write to the data port sends one byte to video memory through a single-cycle request. The pointer then steps forward by one and wraps at the top of the 16 KiB space. The register contents leave the block on a flat bus so that the display pipeline can read them.

Top module: `vdp_cpu_port`

## Requirements
- R1: After reset, the registers hold VR0=0x00 (32×24 tile graphics), VR1=0xC0 (display enabled, interrupts off), VR2=0x00, VR3=0x10, VR4=0x01, VR5=0x0A, VR6=0x02 and VR7=0x00. Register k appears on `regs_flat[8k+7:8k]`. The write pointer is 0x0000 and `vram_we` is low.
- R2: A control pair whose second byte has the form 10000nnn (bits 7..3 = 10000) writes the first byte into register nnn. The new value is visible on `regs_flat` in the cycle after the second strobe.
- R3: A control pair whose second byte has the form 01hhhhhh (bits 7..6 = 01) sets the write pointer to {hhhhhh, first byte}.
- R4: A data-port strobe (`cpu_sel`=0) raises `vram_we` for exactly the next cycle. In that cycle `vram_addr` carries the current pointer and `vram_wdata` carries the byte. The pointer then advances by one, so consecutive data writes fill consecutive addresses.
- R5: A second control byte whose top bits are neither 10000 nor 01 (00xxxxxx, 11xxxxxx, or 10 followed by a nonzero bits 5..3) changes neither the registers nor the pointer.
- R6: A data-port strobe returns the control sequence to expecting a first byte. A lone control write followed by a data write therefore does not misalign the next pair.
- R7: A control write never raises `vram_we`. After a run of data writes, the next control write is taken as the first byte of a new pair and changes nothing on its own.
- R8: The write pointer wraps from 0x3FFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe, one cycle per CPU write |
| cpu_sel | input | 1 | 1 selects the control port, 0 selects the data port |
| cpu_data | input | 8 | CPU write data |
| vram_we | output | 1 | Video memory write request |
| vram_addr | output | 14 | Video memory write address |
| vram_wdata | output | 8 | Video memory write data |
| regs_flat | output | 64 | Eight registers, register k in bits 8k+7..8k |

## Verification
The hardest situation to reach from the ports is a control sequence that has gone out of step. That happens when a lone control byte is left pending just before a data write, or just before a data run ends. To reach it, the bench issues single control writes in the middle of data runs. It then checks that a following full pair still lands where the model expects. Every one of the 256 possible second control bytes is also swept, each paired with a distinct first byte and followed by a data write. This shows that each byte's effect on the registers and on the pointer matches the arithmetic model.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;
  localparam int DW   = 8;
  localparam int AW   = 14;
  localparam int NREG = 8;
  localparam int RIW  = $clog2(NREG);
  localparam int HIW  = AW - DW;

  function automatic logic [DW-1:0] reg_reset(input int idx);
    case (idx)
      1:       return 8'hC0;
      3:       return 8'h10;
      4:       return 8'h01;
      5:       return 8'h0A;
      6:       return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_reg_cmd(input logic [DW-1:0] b);
    return b[7:3] == 5'b10000;
  endfunction

  function automatic logic is_addr_cmd(input logic [DW-1:0] b);
    return b[7:6] == 2'b01;
  endfunction

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/vdp_ctrl_seq.sv
module vdp_ctrl_seq
  import vdp_port_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic           sel,
  input  logic [DW-1:0]  din,
  output logic           second_pending,
  output logic           data_evt,
  output logic           reg_wr_evt,
  output logic [RIW-1:0] reg_idx,
  output logic [DW-1:0]  reg_val,
  output logic           addr_ld_evt,
  output logic [AW-1:0]  addr_val
);
  logic          ctl_evt;
  logic [DW-1:0] first_q;

  always_comb begin
    ctl_evt     = wr & sel;
    data_evt    = wr & ~sel;
    reg_wr_evt  = ctl_evt & second_pending & is_reg_cmd(din);
    addr_ld_evt = ctl_evt & second_pending & is_addr_cmd(din);
    reg_idx     = din[RIW-1:0];
    reg_val     = first_q;
    addr_val    = {din[HIW-1:0], first_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_pending <= 1'b0;
      first_q        <= '0;
    end else begin
      if (data_evt)     second_pending <= 1'b0;
      else if (ctl_evt) second_pending <= ~second_pending;
      if (ctl_evt && !second_pending) first_q <= din;
    end
  end
endmodule

// File: rtl/vdp_reg_bank.sv
module vdp_reg_bank
  import vdp_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [RIW-1:0]   idx,
  input  logic [DW-1:0]    val,
  output logic [NREG*DW-1:0] flat
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                      q <= reg_reset(k);
      else if (wr && idx == RIW'(k))   q <= val;
    end
    assign flat[k*DW +: DW] = q;
  end
endmodule

// File: rtl/vdp_addr_unit.sv
module vdp_addr_unit
  import vdp_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          data_evt,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] cur_addr,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      we       <= 1'b0;
      addr     <= '0;
      wdata    <= '0;
    end else begin
      we <= data_evt;
      if (load) begin
        cur_addr <= load_val;
      end else if (data_evt) begin
        cur_addr <= next_addr(cur_addr);
        addr     <= cur_addr;
        wdata    <= din;
      end
    end
  end
endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
  import vdp_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic        cpu_sel,
  input  logic [7:0]  cpu_data,
  output logic        vram_we,
  output logic [13:0] vram_addr,
  output logic [7:0]  vram_wdata,
  output logic [63:0] regs_flat
);
  logic           second_pending;
  logic           data_evt;
  logic           reg_wr_evt;
  logic [RIW-1:0] reg_idx;
  logic [DW-1:0]  reg_val;
  logic           addr_ld_evt;
  logic [AW-1:0]  addr_val;
  logic [AW-1:0]  cur_addr;

  vdp_ctrl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .sel(cpu_sel), .din(cpu_data),
    .second_pending(second_pending), .data_evt(data_evt),
    .reg_wr_evt(reg_wr_evt), .reg_idx(reg_idx), .reg_val(reg_val),
    .addr_ld_evt(addr_ld_evt), .addr_val(addr_val)
  );

  vdp_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr_evt), .idx(reg_idx),
    .val(reg_val), .flat(regs_flat)
  );

  vdp_addr_unit u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_ld_evt), .load_val(addr_val),
    .data_evt(data_evt), .din(cpu_data), .cur_addr(cur_addr),
    .we(vram_we), .addr(vram_addr), .wdata(vram_wdata)
  );
endmodule

// File: rtl/vdp_cpu_port_chk.sv
module vdp_cpu_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cpu_data,
  input logic        data_evt,
  input logic        reg_wr_evt,
  input logic        addr_ld_evt,
  input logic        second_pending,
  input logic [13:0] cur_addr,
  input logic        vram_we,
  input logic [13:0] vram_addr,
  input logic [7:0]  vram_wdata,
  input logic [63:0] regs_flat
);
  p_write_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_evt |=> vram_we && vram_wdata == $past(cpu_data));

  p_no_spurious_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_evt |=> !vram_we);

  p_step_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> cur_addr == vram_addr + 14'd1);

  p_regs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_evt |=> $stable(regs_flat));

  p_pair_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_evt |=> !second_pending);

  p_one_action_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_evt, reg_wr_evt, addr_ld_evt}));

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_evt && !addr_ld_evt |=> $stable(cur_addr));
endmodule

bind vdp_cpu_port vdp_cpu_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_data(cpu_data), .data_evt(data_evt),
  .reg_wr_evt(reg_wr_evt), .addr_ld_evt(addr_ld_evt),
  .second_pending(second_pending), .cur_addr(cur_addr),
  .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
  .regs_flat(regs_flat)
);

// File: tb/vdp_cpu_port_tb_top.sv
`timescale 1ns/1ps
module vdp_cpu_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        cpu_sel = 1'b0;
  logic [7:0]  cpu_data = 8'h00;
  logic        vram_we;
  logic [13:0] vram_addr;
  logic [7:0]  vram_wdata;
  logic [63:0] regs_flat;

  int checks = 0;
  int failures = 0;
  logic [7:0]  exp_reg [8];
  logic [13:0] exp_addr;

  always #5 clk = ~clk;

  vdp_cpu_port dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_data(cpu_data), .vram_we(vram_we), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata), .regs_flat(regs_flat)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_flat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = exp_reg[k];
    return f;
  endfunction

  // one CPU write; returns at the negedge after the capturing posedge
  task automatic cpu_write(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic data_write(input logic [7:0] d, input string tag);
    cpu_write(1'b0, d);
    chk(vram_we == 1'b1, tag, 64'(vram_we), 64'd1);
    chk(vram_addr == exp_addr, tag, 64'(vram_addr), 64'(exp_addr));
    chk(vram_wdata == d, tag, 64'(vram_wdata), 64'(d));
    exp_addr = exp_addr + 14'd1;
  endtask

  task automatic ctl_write(input logic [7:0] d, input string tag);
    cpu_write(1'b1, d);
    chk(vram_we == 1'b0, tag, 64'(vram_we), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    exp_reg[0] = 8'h00; exp_reg[1] = 8'hC0; exp_reg[2] = 8'h00;
    exp_reg[3] = 8'h10; exp_reg[4] = 8'h01; exp_reg[5] = 8'h0A;
    exp_reg[6] = 8'h02; exp_reg[7] = 8'h00;
    exp_addr = 14'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, then pointer starts at zero
    chk(regs_flat == exp_flat(), "R1 regs", regs_flat, exp_flat());
    chk(vram_we == 1'b0, "R1 we", 64'(vram_we), 64'd0);
    data_write(8'h3C, "R1 ptr zero");

    // R2/R3/R5: sweep every second control byte
    for (int s = 0; s < 256; s++) begin
      logic [7:0] sb;
      logic [7:0] fb;
      string tag;
      sb = 8'(s);
      fb = sb ^ 8'hA5;
      if (sb[7:3] == 5'b10000) begin
        exp_reg[sb[2:0]] = fb; tag = "R2";
      end else if (sb[7:6] == 2'b01) begin
        exp_addr = {sb[5:0], fb}; tag = "R3";
      end else begin
        tag = "R5";
      end
      ctl_write(fb, "R7 first byte no write");
      ctl_write(sb, "R7 second byte no write");
      chk(regs_flat == exp_flat(), tag, regs_flat, exp_flat());
      data_write(sb + 8'd3, tag);
    end

    // R4: consecutive run, then strobe low afterwards
    ctl_write(8'h40, "R3"); ctl_write(8'h52, "R3");
    exp_addr = 14'h1240;
    for (int i = 0; i < 6; i++) data_write(8'(8'h90 + i), "R4 run");
    @(negedge clk);
    chk(vram_we == 1'b0, "R4 single pulse", 64'(vram_we), 64'd0);

    // R6: lone control byte, then data, then a full register pair
    ctl_write(8'h87, "R6 stray");
    data_write(8'h11, "R6 data after stray");
    ctl_write(8'h5E, "R6"); ctl_write(8'h83, "R6");
    exp_reg[3] = 8'h5E;
    chk(regs_flat == exp_flat(), "R6 realigned", regs_flat, exp_flat());

    // R7: control write after a data run alone changes nothing
    data_write(8'h22, "R7");
    ctl_write(8'h85, "R7 lone after run");
    chk(regs_flat == exp_flat(), "R7 regs unchanged", regs_flat, exp_flat());
    data_write(8'h23, "R7 ptr unchanged");

    // R8: wrap at top of space
    ctl_write(8'hFE, "R8"); ctl_write(8'h7F, "R8");
    exp_addr = 14'h3FFE;
    data_write(8'hA1, "R8");
    data_write(8'hA2, "R8");
    chk(exp_addr == 14'h0000, "R8 model wrap", 64'(exp_addr), 64'd0);
    data_write(8'hA3, "R8 wrapped");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule